// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block sits between a CPU's upper address space and a large program ROM. It turns each CPU address in the range 0x6000 to 0xFFFF into a physical ROM address. The CPU programs it through plain register writes. Four bank registers and two configuration words are loaded from two write pages. A three-bit layout mode then decides how the 32 KB region at 0x8000 is cut into windows. The region can be one 32 KB window, two 16 KB windows, or four 8 KB windows, and some windows hold a fixed bank. A three-bit outer bank supplies the top address bits, so one large ROM can hold several independent images.

An optional 8 KB ROM window at 0x6000 takes its bank from bank register 3. Each mode places that bank in its own way. An enable bit turns this window on, and a separate output reports that bit, so the system can route 0x6000 accesses to RAM when the window is off.

The lookup path is purely combinational. There is no handshake on it, because a new CPU address is presented every cycle and the ROM address must follow it within the same cycle. The only state is the register file. A write becomes visible on the lookup path in the cycle after the clock edge that accepts it.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the layout mode is 0, the 0x6000 ROM window is disabled, the outer bank is 0, and every bank register holds all ones. The reset mapping is therefore 0x8000 to 0x38000 and 0xFFFF to 0x3FFFF.
- R2: A write with `wr_en` high to any address with bits [15:12] = 0x8 loads bank register `wr_addr[1:0]` from `wr_data[5:0]`; `wr_data[7:6]` are ignored. Writes to page 0xD load the configuration:
  - offset 0 takes the mode from `wr_data[2:0]` and the 0x6000 enable from `wr_data[7]`;
  - offset 3 takes the outer bank from `wr_data[2:0]`;
  - offsets 1 and 2, all other pages, and cycles with `wr_en` low change nothing.
- R3: Mode 0 maps one 32 KB window at 0x8000 whose bank is {outer[2:0], bank3[2:0]}.
- R4: Mode 1 maps a 16 KB window at 0x8000 with bank {outer[2:0], bank1[3:0]}. 0xC000 holds the fixed 16 KB bank {outer[2:0], 4'hF}.
- R5: Modes 2 and 3 map 8 KB windows at 0x8000, 0xA000 and 0xC000 with bank {outer[2:0], bankN[4:0]} for N = 0, 1, 2. 0xE000 holds the fixed bank {outer[2:0], 5'h1F}.
- R6: Mode 4 maps one 32 KB window with bank {outer[2:1], bank3[3:0]}.
- R7: Mode 5 maps 16 KB at 0x8000 with bank {outer[2:1], bank1[4:0]} and 16 KB at 0xC000 with bank {outer[2:1], bank3[4:0]}.
- R8: Modes 6 and 7 map four 8 KB windows, 0x8000 upward, with bank {outer[2:1], bankN[5:0]} for N = 0 to 3.
- R9: When enabled, the 8 KB window at 0x6000 uses one of these banks:
  - modes 0 and 4: {outer[2:1], bank3[3:0], 2'b11};
  - modes 1 and 5: {outer[2:1], bank3[4:0], 1'b1};
  - modes 2 and 3: {outer[2:0], bank3[4:0]};
  - modes 6 and 7: {outer[2:1], bank3[5:0]}.
  
  `low_rom_en` shows the enable bit.
- R10: `rom_addr` is the bank number shifted left by the window size (15, 14 or 13 bits), ORed with the CPU offset inside the window. `rom_sel` is 1 for addresses at 0x8000 and above, and for 0x6000 to 0x7FFF when the window is enabled. It is 0 below 0x6000.
- R11: The lookup is combinational in `cpu_addr`, and a register write changes the mapping only after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 16 | CPU access address to translate |
| rom_addr | output | 21 | Physical ROM address |
| rom_sel | output | 1 | Access maps to ROM |
| low_rom_en | output | 1 | 0x6000 ROM window enabled |

## Verification
The hardest thing to expose from the ports is a wrong bit slice or shift in a mode's bank formula. With bank values such as all ones, a slice error produces the same address. The stimulus therefore loads bank values with distinct, asymmetric bit patterns and an odd outer bank, so that every dropped, extra or misplaced bit changes the physical address. It then sweeps all eight modes over every window, including the 0x6000 window. The mirrored bank page, the spare configuration offsets and the ignored high data bits are reached by writes whose effect would show in an address that was checked just before.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int CPU_AW    = 16;
  localparam int DATA_W    = 8;
  localparam int BANK_W    = 6;
  localparam int NUM_BANKS = 4;
  localparam int OUTER_W   = 3;
  localparam int MODE_W    = 3;
  localparam int UNIT_W    = 8;   // bank number counted in 8 KB units
  localparam int OFS_W     = 13;  // offset inside an 8 KB unit
  localparam int ROM_AW    = UNIT_W + OFS_W;
  localparam int SLOTS     = 4;   // 8 KB slots in 0x8000-0xFFFF
  localparam int SLOT_W    = $clog2(SLOTS);

  typedef logic [UNIT_W-1:0] unit_t;

  typedef enum logic [MODE_W-1:0] {
    LAY_32K_FULL = 3'd0,
    LAY_16K_FIX  = 3'd1,
    LAY_8K_FIX   = 3'd2,
    LAY_8K_FIXB  = 3'd3,
    LAY_32K_NARW = 3'd4,
    LAY_16K_SW   = 3'd5,
    LAY_8K_SW    = 3'd6,
    LAY_8K_SWB   = 3'd7
  } layout_e;

  typedef struct packed {
    logic                low_rom;
    layout_e             mode;
    logic [OUTER_W-1:0]  outer;
  } map_cfg_t;
endpackage

// File: rtl/prg_cfg_regs.sv
module prg_cfg_regs
  import prg_map_pkg::*;
#(
  parameter logic [3:0] PAGE_BANK = 4'h8,
  parameter logic [3:0] PAGE_CTRL = 4'hD
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [CPU_AW-1:0]                    wr_addr,
  input  logic [DATA_W-1:0]                    wr_data,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]     bank_q,
  output map_cfg_t                             cfg_q
);
  logic hit_bank, hit_ctrl;
  logic [1:0] sub;

  assign hit_bank = wr_en && (wr_addr[CPU_AW-1 -: 4] == PAGE_BANK);
  assign hit_ctrl = wr_en && (wr_addr[CPU_AW-1 -: 4] == PAGE_CTRL);
  assign sub      = wr_addr[1:0];

  logic unused_wr;
  assign unused_wr = ^{wr_addr[11:2], wr_data[6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '1;                       // R1
      cfg_q  <= '{low_rom: 1'b0, mode: LAY_32K_FULL, outer: '0};
    end else begin
      if (hit_bank) bank_q[sub] <= wr_data[BANK_W-1:0];
      if (hit_ctrl) begin
        unique case (sub)
          2'd0: begin
            cfg_q.mode    <= layout_e'(wr_data[MODE_W-1:0]);
            cfg_q.low_rom <= wr_data[DATA_W-1];
          end
          2'd3: cfg_q.outer <= wr_data[OUTER_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assert_bank_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_bank |=> bank_q[$past(sub)] == $past(wr_data[BANK_W-1:0]));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_bank && !hit_ctrl) |=> ($stable(bank_q) && $stable(cfg_q)));

  assert_ctrl_spare_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctrl && (sub == 2'd1 || sub == 2'd2)) |=> $stable(cfg_q));
endmodule

// File: rtl/prg_slot_unit.sv
module prg_slot_unit
  import prg_map_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  map_cfg_t                         cfg,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q,
  output unit_t                            unit
);
  localparam logic [SLOT_W-1:0] SIDX = SLOT_W'(SLOT);
  localparam bit LOWER_HALF = (SLOT < SLOTS/2);
  localparam bit TOP_SLOT   = (SLOT == SLOTS-1);

  logic [OUTER_W-1:0] o;
  logic [BANK_W-1:0]  b_own, b1, b3;
  assign o     = cfg.outer;
  assign b_own = bank_q[SLOT];
  assign b1    = bank_q[1];
  assign b3    = bank_q[3];

  logic unused_in;
  assign unused_in = ^{bank_q, cfg.low_rom};

  always_comb begin
    unique case (cfg.mode)
      LAY_32K_FULL: unit = {o, b3[2:0], SIDX};                              // R3
      LAY_16K_FIX:  unit = LOWER_HALF ? {o, b1[3:0], SIDX[0]}
                                      : {o, 4'hF, SIDX[0]};                 // R4
      LAY_8K_FIX,
      LAY_8K_FIXB:  unit = TOP_SLOT ? {o, 5'h1F} : {o, b_own[4:0]};          // R5
      LAY_32K_NARW: unit = {o[2:1], b3[3:0], SIDX};                         // R6
      LAY_16K_SW:   unit = LOWER_HALF ? {o[2:1], b1[4:0], SIDX[0]}
                                      : {o[2:1], b3[4:0], SIDX[0]};         // R7
      LAY_8K_SW,
      LAY_8K_SWB:   unit = {o[2:1], b_own[5:0]};                            // R8
      default:      unit = '0;
    endcase
  end
endmodule

// File: rtl/prg_low_unit.sv
module prg_low_unit
  import prg_map_pkg::*;
(
  input  map_cfg_t                         cfg,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q,
  output unit_t                            unit
);
  logic [OUTER_W-1:0] o;
  logic [BANK_W-1:0]  b3;
  assign o  = cfg.outer;
  assign b3 = bank_q[3];

  logic unused_in;
  assign unused_in = ^{bank_q, cfg.low_rom};

  // R9: per-layout placement of the 0x6000 window bank
  always_comb begin
    unique case (cfg.mode)
      LAY_32K_FULL, LAY_32K_NARW: unit = {o[2:1], b3[3:0], 2'b11};
      LAY_16K_FIX,  LAY_16K_SW:   unit = {o[2:1], b3[4:0], 1'b1};
      LAY_8K_FIX,   LAY_8K_FIXB:  unit = {o, b3[4:0]};
      LAY_8K_SW,    LAY_8K_SWB:   unit = {o[2:1], b3[5:0]};
      default:                    unit = '0;
    endcase
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter logic [3:0] PAGE_BANK = 4'h8,
  parameter logic [3:0] PAGE_CTRL = 4'hD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [15:0]       cpu_addr,
  output logic [20:0]       rom_addr,
  output logic              rom_sel,
  output logic              low_rom_en
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q;
  map_cfg_t                         cfg;
  unit_t                            slot_unit [SLOTS];
  unit_t                            low_unit;
  unit_t                            cur_unit;
  logic                             in_low_win;

  prg_cfg_regs #(.PAGE_BANK(PAGE_BANK), .PAGE_CTRL(PAGE_CTRL)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .bank_q  (bank_q),
    .cfg_q   (cfg)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    prg_slot_unit #(.SLOT(s)) u_slot (
      .cfg    (cfg),
      .bank_q (bank_q),
      .unit   (slot_unit[s])
    );
  end

  prg_low_unit u_low (
    .cfg    (cfg),
    .bank_q (bank_q),
    .unit   (low_unit)
  );

  // R10/R11: combinational translation of the current access
  assign in_low_win = (cpu_addr[15:13] == 3'b011);
  assign cur_unit   = cpu_addr[15] ? slot_unit[cpu_addr[14:13]] : low_unit;
  assign rom_addr   = {cur_unit, cpu_addr[OFS_W-1:0]};
  assign rom_sel    = cpu_addr[15] | (in_low_win & cfg.low_rom);
  assign low_rom_en = cfg.low_rom;

  assert_below_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> !rom_sel);

  assert_slice_32k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15] && cfg.mode == LAY_32K_FULL) |-> rom_addr[14:13] == cpu_addr[14:13]);

  assert_fixed_c000_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11 && cfg.mode == LAY_16K_FIX) |-> rom_addr[17:14] == 4'hF);

  assert_fixed_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111 && cfg.mode[2:1] == 2'b01) |-> rom_addr[17:13] == 5'h1F);

  assert_low_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode[2:1] == 2'b11) |-> low_unit == slot_unit[3]);
endmodule

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] addr;
    logic [20:0] exp_addr;
    logic        exp_sel;
    logic [3:0]  req;
  } vec_t;

  // banks 0x25,0x3A,0x11,0x2D, outer 5, loaded before the walk
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'h80, 16'h9234, 21'h169234, 1'b1, 4'd3},   // R3
    '{8'h80, 16'h6010, 21'h16E010, 1'b1, 4'd9},   // R9
    '{8'h81, 16'h8ABC, 21'h168ABC, 1'b1, 4'd4},   // R4
    '{8'h81, 16'hD001, 21'h17D001, 1'b1, 4'd4},
    '{8'h81, 16'h7FFF, 21'h137FFF, 1'b1, 4'd9},
    '{8'h82, 16'hA005, 21'h174005, 1'b1, 4'd5},   // R5
    '{8'h82, 16'hE123, 21'h17E123, 1'b1, 4'd5},
    '{8'h82, 16'h6800, 21'h15A800, 1'b1, 4'd9},
    '{8'h83, 16'hC0FF, 21'h1620FF, 1'b1, 4'd5},
    '{8'h84, 16'hF00F, 21'h16F00F, 1'b1, 4'd6},   // R6
    '{8'h84, 16'h6000, 21'h16E000, 1'b1, 4'd9},
    '{8'h85, 16'h8001, 21'h168001, 1'b1, 4'd7},   // R7
    '{8'h85, 16'hC002, 21'h134002, 1'b1, 4'd7},
    '{8'h85, 16'h6004, 21'h136004, 1'b1, 4'd9},
    '{8'h86, 16'hA100, 21'h174100, 1'b1, 4'd8},   // R8
    '{8'h86, 16'hE000, 21'h15A000, 1'b1, 4'd8},
    '{8'h86, 16'h7000, 21'h15B000, 1'b1, 4'd9},
    '{8'h87, 16'h8000, 21'h14A000, 1'b1, 4'd8},
    '{8'h06, 16'h6000, 21'h000000, 1'b0, 4'd9},
    '{8'h06, 16'h5000, 21'h000000, 1'b0, 4'd10}   // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cpu_addr = '0;
  logic [20:0] rom_addr;
  logic        rom_sel;
  logic        low_rom_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_mapper u_prg_bank_mapper (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cpu_addr   (cpu_addr),
    .rom_addr   (rom_addr),
    .rom_sel    (rom_sel),
    .low_rom_en (low_rom_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    cpu_addr = a;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state seen through the mapping
    look(16'h8000); check("R1 reset 0x8000", 32'(rom_addr), 32'h38000);
    check("R1 reset sel", 32'(rom_sel), 32'd1);
    look(16'hFFFF); check("R1 reset 0xFFFF", 32'(rom_addr), 32'h3FFFF);
    look(16'h6000); check("R1 low window off", 32'(rom_sel), 32'd0);
    check("R1 low enable flag", 32'(low_rom_en), 32'd0);

    do_write(16'h8000, 8'h25);
    do_write(16'h8001, 8'h3A);
    do_write(16'h8002, 8'h11);
    do_write(16'h8003, 8'h2D);
    do_write(16'hD003, 8'h05);

    for (int i = 0; i < NV; i++) begin
      do_write(16'hD000, VECS[i].ctrl);
      look(VECS[i].addr);
      check($sformatf("R%0d sel @%h", VECS[i].req, VECS[i].addr), 32'(rom_sel), 32'(VECS[i].exp_sel));
      check($sformatf("R%0d flag @%h", VECS[i].req, VECS[i].addr), 32'(low_rom_en), 32'(VECS[i].ctrl[7]));
      if (VECS[i].exp_sel)
        check($sformatf("R%0d addr @%h", VECS[i].req, VECS[i].addr), 32'(rom_addr), 32'(VECS[i].exp_addr));
    end

    // R2: spare control offsets, idle strobe and foreign page leave mapping alone
    do_write(16'hD000, 8'h86);
    look(16'hA100); check("R8 baseline", 32'(rom_addr), 32'h174100);
    do_write(16'hD001, 8'hFF);
    do_write(16'hD002, 8'hFF);
    look(16'hA100); check("R2 spare ctrl offsets", 32'(rom_addr), 32'h174100);
    check("R2 spare ctrl flag", 32'(low_rom_en), 32'd1);
    @(negedge clk); wr_en = 1'b0; wr_addr = 16'h8001; wr_data = 8'h00;
    @(negedge clk);
    look(16'hA100); check("R2 strobe low", 32'(rom_addr), 32'h174100);
    do_write(16'h9001, 8'h00);
    look(16'hA100); check("R2 foreign page", 32'(rom_addr), 32'h174100);
    do_write(16'hD003, 8'hF8);
    look(16'hA100); check("R2 outer high bits ignored", 32'(rom_addr), 32'h074100);

    // R11: mirrored bank page write, visible only after its edge
    @(negedge clk);
    cpu_addr = 16'hA100; wr_en = 1'b1; wr_addr = 16'h8FF1; wr_data = 8'h00;
    #1; check("R11 before edge", 32'(rom_addr), 32'h074100);
    @(negedge clk);
    wr_en = 1'b0;
    #1; check("R11 after edge mirror", 32'(rom_addr), 32'h000100);

    // R2: data bits 7:6 of a bank write have no effect
    do_write(16'h8001, 8'hC0);
    look(16'hA100); check("R2 bank high bits", 32'(rom_addr), 32'h000100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule